// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block turns bytes handed to it by a bus master into asynchronous serial frames on a transmit pin. Each frame is one low start bit, then eight data bits starting with the least significant, then one high stop bit. There is no parity bit. The bit period is set by a 20-bit divisor input. Each bit lasts one clock cycle more than the divisor value.

A write strobe carries a byte. If the shift register is still sending the previous frame, the block raises a stall output. The master keeps the byte on the bus until the stall drops, so no byte is lost and software never has to poll. A ready flag is exported for status.

A two-bit line mode selects what drives the transmit pin:
- the frame shifter;
- the receive input, echoed straight back;
- a forced low level (break);
- a forced high level (mark).

The raw shifter output is always exported, so a neighbouring receiver can be looped back locally.

Top module: `serial_tx_line`

## Requirements
- R1: A frame on `tx_raw` is a start bit of 0, then `wr_data` bit 0 through bit 7, then a stop bit of 1. With `line_mode` = 2'b00, `txd` carries the same levels.
- R2: Every bit of a frame lasts exactly `divisor`+1 clock cycles. A divisor of 0 gives one bit per clock cycle.
- R3: While `tx_ready` is 1, a cycle with `wr_en` = 1 is accepted with `wr_stall` = 0. The start bit appears on `tx_raw` from the next clock cycle, and `tx_ready` is 0 from that same cycle.
- R4: A write presented while `tx_ready` is 0 sees `wr_stall` = 1 until the cycle in which `tx_ready` is 1 again. In that cycle the write is accepted with `wr_stall` = 0, and the held byte is then sent in full.
- R5: `tx_ready` stays 0 for exactly 10×(`divisor`+1) cycles after an accepted write. It then returns to 1. It never falls without an accepted write.
- R6: While `tx_ready` is 1, `tx_raw` is 1. With `line_mode` = 2'b00, `txd` is also 1.
- R7: With `line_mode` = 2'b01, `txd` follows `rxd` in the same cycle and never shows written data. `tx_raw` still carries the frame.
- R8: With `line_mode` = 2'b10, `txd` is 0. With `line_mode` = 2'b11, `txd` is 1. This holds whatever the shifter is doing.
- R9: A change of `divisor` during a frame leaves the current bit at its old length. The new value applies from the next bit onwards.
- R10: After reset, `tx_ready` = 1, `wr_stall` = 0 and `tx_raw` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| divisor | input | DIV_W (20) | Bit period minus one, in clock cycles |
| line_mode | input | 2 | Pin source: 00 shifter, 01 echo of rxd, 10 forced 0, 11 forced 1 |
| wr_en | input | 1 | Write strobe; held by the master while stalled |
| wr_data | input | DATA_W (8) | Byte to transmit |
| wr_stall | output | 1 | Write is waiting for the shift register |
| tx_ready | output | 1 | Shift register idle, able to take a byte |
| rxd | input | 1 | Serial receive input, used for echo |
| txd | output | 1 | Serial transmit pin |
| tx_raw | output | 1 | Raw shifter output for local loopback |

## Verification
The bench builds the block with its default widths: a 20-bit divisor and 8-bit data. It drives only small divisor values (0 to 5). That keeps each frame to a few dozen cycles, so every cycle of every frame can be compared with the expected level. It also brings the one-clock-per-bit case, the back-to-back stall case and a divisor change in the middle of a frame within reach in a short run. The full 20-bit divisor path is still elaborated, so the width of the bit counter and its compare is covered by the same build.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    LM_SHIFT = 2'b00,
    LM_ECHO  = 2'b01,
    LM_SPACE = 2'b10,
    LM_MARK  = 2'b11
  } line_mode_e;

  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned DIV_BITS   = 20;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;

endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             at_lim;
  logic             cnt_en;

  // The limit is sampled only at a load or a bit boundary (R9).
  assign at_lim = (cnt_q == lim_q);
  assign tick   = run & at_lim;
  assign cnt_en = load | run;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load || tick) begin
      cnt_d = '0;
      lim_d = divisor;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

endmodule

// File: rtl/stx_frame_shifter.sv
module stx_frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              raw
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               busy_q, busy_d;
  logic               sh_en;

  assign sh_en = load | tick;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = {1'b1, data, 1'b0};
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (tick) begin
      sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign raw  = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/stx_line_sel.sv
module stx_line_sel
  import stx_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       shift_bit,
  input  logic       rxd,
  output logic       pin
);

  line_mode_e sel;
  assign sel = line_mode_e'(mode);

  always_comb begin
    unique case (sel)
      LM_SHIFT: pin = shift_bit;
      LM_ECHO:  pin = rxd;
      LM_SPACE: pin = 1'b0;
      LM_MARK:  pin = 1'b1;
      default:  pin = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_tx_line.sv
module serial_tx_line #(
  parameter int DIV_W  = stx_pkg::DIV_BITS,
  parameter int DATA_W = stx_pkg::DATA_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        line_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stall,
  output logic              tx_ready,
  input  logic              rxd,
  output logic              txd,
  output logic              tx_raw
);

  // Asynchronous assertion, synchronous release.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic busy;
  logic tick;
  logic accept;
  logic raw_bit;

  assign accept   = wr_en & ~busy;
  assign wr_stall = wr_en & busy;
  assign tx_ready = ~busy;
  assign tx_raw   = raw_bit;

  stx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (accept),
    .run     (busy),
    .divisor (divisor),
    .tick    (tick)
  );

  stx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (accept),
    .tick  (tick),
    .data  (wr_data),
    .busy  (busy),
    .raw   (raw_bit)
  );

  stx_line_sel u_sel (
    .mode      (line_mode),
    .shift_bit (raw_bit),
    .rxd       (rxd),
    .pin       (txd)
  );

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_stall,
  input logic       tx_ready,
  input logic       tx_raw,
  input logic       txd,
  input logic       rxd,
  input logic [1:0] line_mode
);

  p_stall_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> !tx_ready);

  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_ready) |=> (!tx_ready && !tx_raw));

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> !tx_raw);

  p_stop_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(tx_raw));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(wr_en));

  p_idle_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_raw);

  p_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mode == 2'b01) |-> (txd == rxd));

  p_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_mode[1] |-> (txd == line_mode[0]));

endmodule

bind serial_tx_line stx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_stall  (wr_stall),
  .tx_ready  (tx_ready),
  .tx_raw    (tx_raw),
  .txd       (txd),
  .rxd       (rxd),
  .line_mode (line_mode)
);

// File: tb/serial_tx_line_tb_top.sv
module serial_tx_line_tb_top;

  localparam int DIV_W  = 20;
  localparam int DATA_W = 8;
  localparam int NVEC   = 6;
  localparam int WD_CYCLES = 200000;

  // {mode[1:0], divisor[19:0], data[7:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'b00, 20'd0, 8'hA5},
    {2'b00, 20'd2, 8'h3C},
    {2'b01, 20'd1, 8'h81},
    {2'b10, 20'd1, 8'h5A},
    {2'b11, 20'd0, 8'h0F},
    {2'b00, 20'd5, 8'hFF}
  };

  logic              clk;
  logic              rst_n;
  logic [DIV_W-1:0]  divisor;
  logic [1:0]        line_mode;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              wr_stall;
  logic              tx_ready;
  logic              rxd;
  logic              txd;
  logic              tx_raw;

  int checks;
  int failures;
  bit done;

  serial_tx_line #(.DIV_W(DIV_W), .DATA_W(DATA_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .divisor   (divisor),
    .line_mode (line_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_stall  (wr_stall),
    .tx_ready  (tx_ready),
    .rxd       (rxd),
    .txd       (txd),
    .tx_raw    (tx_raw)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_pin(input logic [1:0] mode, input logic shift_bit, input logic rx);
    case (mode)
      2'b00:   return shift_bit;
      2'b01:   return rx;
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Caller stands at the first negedge after the load edge.
  task automatic verify_frame(input logic [1:0] mode, input int d, input logic [7:0] data);
    logic [9:0] frame;
    int total;
    frame = {1'b1, data, 1'b0};
    total = 10 * (d + 1);
    for (int i = 0; i < total; i++) begin
      logic eb;
      if (i > 0) @(negedge clk);
      rxd = ((i % 3) == 1);
      #1;
      eb = frame[i / (d + 1)];
      check(tx_raw == eb, "R1/R2 frame bit on tx_raw", int'(tx_raw), int'(eb));
      check(tx_ready == 1'b0, "R5 ready low during frame", int'(tx_ready), 0);
      if (mode == 2'b00)
        check(txd == eb, "R1 txd carries frame", int'(txd), int'(eb));
      else if (mode == 2'b01)
        check(txd == rxd, "R7 echo of rxd", int'(txd), int'(rxd));
      else
        check(txd == exp_pin(mode, eb, rxd), "R8 forced level", int'(txd), int'(mode[0]));
    end
    @(negedge clk);
    #1;
    check(tx_ready == 1'b1, "R5 ready back after stop bit", int'(tx_ready), 1);
    check(tx_raw == 1'b1, "R6 idle line at mark", int'(tx_raw), 1);
  endtask

  task automatic send_frame(input logic [1:0] mode, input int d, input logic [7:0] data);
    @(negedge clk);
    line_mode = mode;
    divisor   = DIV_W'(d);
    wr_en     = 1'b1;
    wr_data   = data;
    #1;
    check(wr_stall == 1'b0, "R3 idle write not stalled", int'(wr_stall), 0);
    @(negedge clk);
    wr_en = 1'b0;
    verify_frame(mode, d, data);
  endtask

  initial begin
    checks    = 0;
    failures  = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    divisor   = '0;
    line_mode = 2'b00;
    wr_en     = 1'b0;
    wr_data   = '0;
    rxd       = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10 reset state
    check(tx_ready == 1'b1, "R10 ready after reset", int'(tx_ready), 1);
    check(wr_stall == 1'b0, "R10 no stall after reset", int'(wr_stall), 0);
    check(tx_raw == 1'b1, "R10 raw at mark after reset", int'(tx_raw), 1);
    check(txd == 1'b1, "R6 pin at mark when idle", int'(txd), 1);

    // Vector table walk: R1, R2, R3, R5, R6, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][29:28], int'(VEC[v][27:8]), VEC[v][7:0]);
    end

    // R4: back-to-back writes, second one stalled until ready
    begin
      int stall_cnt;
      @(negedge clk);
      line_mode = 2'b00;
      divisor   = 20'd1;
      wr_en     = 1'b1;
      wr_data   = 8'hC3;
      @(negedge clk);
      wr_data   = 8'h69;
      stall_cnt = 0;
      #1;
      while (wr_stall && stall_cnt < 100) begin
        check(tx_ready == 1'b0, "R4 stall only while busy", int'(tx_ready), 0);
        stall_cnt++;
        @(negedge clk);
        #1;
      end
      check(stall_cnt == 20, "R4 stall length", stall_cnt, 20);
      check(tx_ready == 1'b1, "R4 release when ready", int'(tx_ready), 1);
      @(negedge clk);
      wr_en = 1'b0;
      verify_frame(2'b00, 1, 8'h69);
    end

    // R9: divisor change in the middle of the start bit
    begin
      logic [9:0] frame;
      frame = {1'b1, 8'h96, 1'b0};
      @(negedge clk);
      line_mode = 2'b00;
      divisor   = 20'd3;
      wr_en     = 1'b1;
      wr_data   = 8'h96;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < 22; i++) begin
        int k;
        if (i > 0) @(negedge clk);
        if (i == 1) divisor = 20'd1;
        #1;
        k = (i < 4) ? 0 : 1 + (i - 4) / 2;
        check(tx_raw == frame[k], "R9 bit length after divisor change", int'(tx_raw), int'(frame[k]));
        check(tx_ready == 1'b0, "R9 busy through frame", int'(tx_ready), 0);
      end
      @(negedge clk);
      #1;
      check(tx_ready == 1'b1, "R9 frame ends on new timing", int'(tx_ready), 1);
    end

    // R7: echo mode while idle, rxd low and high
    @(negedge clk);
    line_mode = 2'b01;
    rxd = 1'b0;
    #1;
    check(txd == 1'b0, "R7 echo low", int'(txd), 0);
    rxd = 1'b1;
    #1;
    check(txd == 1'b1, "R7 echo high", int'(txd), 1);
    line_mode = 2'b00;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule